// File: doc/BRIEF.md
# Pipelined Bus Requester Port

This block is the per-device front end of a synchronous shared bus whose transfers are split into separate cycles. A local agent asks to send one 64-bit packet by pulsing `send_i` while the port is idle. The port captures the packet fields in a holding register and raises a request toward a central arbiter. The request travels through a chain of clocked stages first. The arbiter answers with a registered acknowledge. While that acknowledge is high the port withdraws its request, and it drives the packet onto the bus in the following cycle.

At the end of that single owned cycle the port samples the receivers' shared accept line. If no receiver claimed the packet, the port sets a sticky nonexistent-device error. Software-free operation is intended: the error flag is cleared by a one-cycle pulse on `err_clr_i`. The port stays busy from the cycle after a request is taken until the cycle after the transfer, and it accepts one packet at a time.

Top module: `bus_req_port`

## Requirements
- R1: After synchronous reset, `busy_o`, `req_o`, `bus_en_o`, `bus_pkt_o` and `nxd_err_o` are all zero.
- R2: `send_i` sampled high while `busy_o` is low captures `data_i`, `dst_i` and `src_i` and sets `busy_o` from the next cycle. `send_i` sampled while `busy_o` is high is ignored and does not alter the captured packet.
- R3: `req_o` first goes high in the third cycle after the cycle in which `send_i` was taken, because it passes two flip-flop stages after the request register. It then stays high until acknowledged.
- R4: `req_o` is low in every cycle in which `ack_i` is high. After an acknowledge that meets a pending request, `req_o` stays low and the request pipeline is empty.
- R5: `ack_i` that arrives while `req_o` would be low (idle, or the request still in the stages) starts no transfer. A pending request still reaches `req_o` later.
- R6: The transfer occupies exactly the cycle after the acknowledge cycle. `bus_en_o` is high for that one cycle, and `bus_pkt_o` carries {dst[63:32], src[31:16], data[15:0]}.
- R7: `bus_pkt_o` is zero in every cycle in which `bus_en_o` is low.
- R8: `accept_i` is sampled at the end of the transfer cycle. If it is low, `nxd_err_o` is high from the next cycle and stays high. If it is high, `nxd_err_o` is unchanged.
- R9: `err_clr_i` high clears `nxd_err_o` in the next cycle. A missing accept in the same cycle wins and leaves the flag set.
- R10: `busy_o` falls in the cycle after the transfer cycle. A `send_i` in that cycle is taken.
- R11: Reset asserted during a pending request drops it. No request or transfer follows after reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| send_i | input | 1 | Local request to send one packet |
| data_i | input | 16 | Packet data field |
| dst_i | input | 32 | Packet destination address |
| src_i | input | 16 | Packet source address |
| ack_i | input | 1 | Registered acknowledge from the arbiter |
| accept_i | input | 1 | Receiver claim of the packet on the bus |
| err_clr_i | input | 1 | Clears the nonexistent-device flag |
| busy_o | output | 1 | A packet is in flight |
| req_o | output | 1 | Request to the arbiter |
| bus_en_o | output | 1 | Port owns the bus this cycle |
| bus_pkt_o | output | 64 | Packet driven on the bus |
| nxd_err_o | output | 1 | Sticky nonexistent-device error |

## Verification
The bench counts the exact cycle in which the request appears after each send. A port with one stage too few or too many would show its request a cycle early or late. It raises the acknowledge while the request is still in the stages, and also while the port is idle. A port that honoured those early grants would drive a spurious bus cycle. It repeats `send_i` with other fields while the port is busy, so a holding register that reloads shows the wrong packet on the bus. It also pairs a missing accept with a clear in the same cycle, and resets mid-request. A port that cleared the flag first, or left a request stage alive, would be caught there.

// File: rtl/bus_req_pkg.sv
package bus_req_pkg;
  localparam int DATA_W = 16;
  localparam int DST_W  = 32;
  localparam int SRC_W  = 16;
  localparam int PKT_W  = DATA_W + DST_W + SRC_W;

  typedef struct packed {
    logic [DST_W-1:0]  dst;
    logic [SRC_W-1:0]  src;
    logic [DATA_W-1:0] data;
  } pkt_t;
endpackage

// File: rtl/brq_sync_chain.sv
module brq_sync_chain #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic flush,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] st;

  genvar i;
  generate
    for (i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) st[0] <= 1'b0;
          else     st[0] <= d & ~flush;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) st[i] <= 1'b0;
          else     st[i] <= st[i-1] & ~flush;
        end
      end
    end
  endgenerate

  assign q = st[STAGES-1];

  // R4
  flush_empty_chk: assert property (@(posedge clk) disable iff (rst)
    flush |=> !q);
endmodule

// File: rtl/brq_pkt_drv.sv
module brq_pkt_drv
  import bus_req_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        load,
  input  logic        grant,
  input  pkt_t        pkt_in,
  output logic        bus_en,
  output logic [PKT_W-1:0] bus_pkt
);
  pkt_t hold_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_q  <= '0;
      bus_en  <= 1'b0;
      bus_pkt <= '0;
    end else begin
      if (load) hold_q <= pkt_in;
      bus_en  <= grant;
      bus_pkt <= grant ? hold_q : '0;
    end
  end

  // R6
  en_once_chk: assert property (@(posedge clk) disable iff (rst)
    bus_en |=> !bus_en);

  // R7
  bus_idle_zero_chk: assert property (@(posedge clk) disable iff (rst)
    !bus_en |-> (bus_pkt == '0));
endmodule

// File: rtl/brq_status.sv
module brq_status (
  input  logic clk,
  input  logic rst,
  input  logic send,
  input  logic grant,
  input  logic accept,
  input  logic err_clr,
  output logic load,
  output logic busy,
  output logic pend,
  output logic nxd_err
);
  logic xfer_q;

  assign load = send & ~busy;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy    <= 1'b0;
      pend    <= 1'b0;
      xfer_q  <= 1'b0;
      nxd_err <= 1'b0;
    end else begin
      if (load)        busy <= 1'b1;
      else if (xfer_q) busy <= 1'b0;
      if (load)        pend <= 1'b1;
      else if (grant)  pend <= 1'b0;
      xfer_q <= grant;
      if (xfer_q && !accept) nxd_err <= 1'b1;
      else if (err_clr)      nxd_err <= 1'b0;
    end
  end

  // R2
  busy_from_send_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(send));

  // R10
  busy_release_chk: assert property (@(posedge clk) disable iff (rst)
    xfer_q |=> !busy);
endmodule

// File: rtl/bus_req_port.sv
module bus_req_port
  import bus_req_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              send_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic [DST_W-1:0]  dst_i,
  input  logic [SRC_W-1:0]  src_i,
  input  logic              ack_i,
  input  logic              accept_i,
  input  logic              err_clr_i,
  output logic              busy_o,
  output logic              req_o,
  output logic              bus_en_o,
  output logic [PKT_W-1:0]  bus_pkt_o,
  output logic              nxd_err_o
);
  logic load, pend, req_q, grant;
  pkt_t pkt_in;

  assign pkt_in = '{dst: dst_i, src: src_i, data: data_i};
  assign grant  = ack_i & req_q;
  assign req_o  = req_q & ~ack_i;

  brq_status u_status (
    .clk(clk), .rst(rst), .send(send_i), .grant(grant),
    .accept(accept_i), .err_clr(err_clr_i),
    .load(load), .busy(busy_o), .pend(pend), .nxd_err(nxd_err_o)
  );

  brq_sync_chain #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .flush(grant), .d(pend), .q(req_q)
  );

  brq_pkt_drv u_drv (
    .clk(clk), .rst(rst), .load(load), .grant(grant),
    .pkt_in(pkt_in), .bus_en(bus_en_o), .bus_pkt(bus_pkt_o)
  );

  // R4
  req_flush_chk: assert property (@(posedge clk) disable iff (rst)
    (ack_i && req_q) |=> !req_q);

  // R6
  xfer_while_busy_chk: assert property (@(posedge clk) disable iff (rst)
    bus_en_o |-> busy_o);
endmodule

// File: tb/bus_req_port_tb.sv
module bus_req_port_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst, send_i, ack_i, accept_i, err_clr_i;
  logic [15:0] data_i, src_i;
  logic [31:0] dst_i;
  logic        busy_o, req_o, bus_en_o, nxd_err_o;
  logic [63:0] bus_pkt_o;

  int errors = 0;
  int checks = 0;
  logic err_exp = 1'b0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bus_req_port u_dut (
    .clk(clk), .rst(rst), .send_i(send_i), .data_i(data_i), .dst_i(dst_i),
    .src_i(src_i), .ack_i(ack_i), .accept_i(accept_i), .err_clr_i(err_clr_i),
    .busy_o(busy_o), .req_o(req_o), .bus_en_o(bus_en_o),
    .bus_pkt_o(bus_pkt_o), .nxd_err_o(nxd_err_o)
  );

  // data, dst, src, extra wait cycles before ack, accept value
  localparam logic [71:0] VEC [4] = '{
    {16'h1234, 32'hDEAD_BEEF, 16'h0001, 3'd0, 4'd0, 1'b1},
    {16'hA5A5, 32'h0000_FFFF, 16'h00F0, 3'd2, 4'd0, 1'b1},
    {16'hFFFF, 32'h8000_0001, 16'hFFFF, 3'd1, 4'd0, 1'b0},
    {16'h0000, 32'h1357_9BDF, 16'h2468, 3'd5, 4'd0, 1'b1}
  };

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic txn(input logic [15:0] d, input logic [31:0] ds,
                     input logic [15:0] s, input int waitn, input logic acc,
                     input logic clr_at_acc);
    logic [63:0] exp_pkt;
    exp_pkt = {ds, s, d};
    send_i = 1'b1; data_i = d; dst_i = ds; src_i = s;
    tick();
    send_i = 1'b0; data_i = ~d; dst_i = ~ds; src_i = ~s;
    chk("R2 busy after send", {63'd0, busy_o}, 64'd1);
    chk("R3 req low stage1", {63'd0, req_o}, 64'd0);
    tick();
    chk("R3 req low stage2", {63'd0, req_o}, 64'd0);
    tick();
    chk("R3 req high third cycle", {63'd0, req_o}, 64'd1);
    for (int k = 0; k < waitn; k++) begin
      send_i = 1'b1;
      tick();
      chk("R3 req held", {63'd0, req_o}, 64'd1);
    end
    send_i = 1'b0;
    ack_i = 1'b1;
    #1;
    chk("R4 req low with ack", {63'd0, req_o}, 64'd0);
    tick();
    ack_i = 1'b0;
    chk("R6 bus_en in transfer", {63'd0, bus_en_o}, 64'd1);
    chk("R6 packet layout", bus_pkt_o, exp_pkt);
    chk("R4 req stays low", {63'd0, req_o}, 64'd0);
    accept_i = acc;
    err_clr_i = clr_at_acc;
    tick();
    accept_i = 1'b0;
    err_clr_i = 1'b0;
    if (!acc) err_exp = 1'b1;
    else if (clr_at_acc) err_exp = 1'b0;
    chk("R7 bus idle zero", {bus_en_o, bus_pkt_o[62:0]}, 64'd0);
    chk("R10 busy released", {63'd0, busy_o}, 64'd0);
    chk("R8 error flag", {63'd0, nxd_err_o}, {63'd0, err_exp});
    chk("R4 pipeline empty", {63'd0, req_o}, 64'd0);
  endtask

  initial begin
    #(CLK_PERIOD*100000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; send_i = 1'b0; ack_i = 1'b0; accept_i = 1'b0; err_clr_i = 1'b0;
    data_i = '0; dst_i = '0; src_i = '0;
    tick(); tick();
    chk("R1 reset outputs",
        {59'd0, busy_o, req_o, bus_en_o, nxd_err_o, |bus_pkt_o}, 64'd0);
    rst = 1'b0;
    tick();

    for (int v = 0; v < 4; v++) begin
      txn(VEC[v][71:56], VEC[v][55:24], VEC[v][23:8], int'(VEC[v][7:5]),
          VEC[v][0], 1'b0);
    end

    // R9: clear pulse drops the flag
    err_clr_i = 1'b1;
    tick();
    err_clr_i = 1'b0;
    err_exp = 1'b0;
    chk("R9 clear", {63'd0, nxd_err_o}, 64'd0);

    // R9: missing accept wins over simultaneous clear
    txn(16'h0BAD, 32'hCAFE_0000, 16'h0077, 0, 1'b0, 1'b1);
    chk("R9 set beats clear", {63'd0, nxd_err_o}, 64'd1);
    err_clr_i = 1'b1;
    tick();
    err_clr_i = 1'b0;
    err_exp = 1'b0;

    // R5: ack while idle
    ack_i = 1'b1;
    tick();
    ack_i = 1'b0;
    tick();
    chk("R5 idle ack no xfer", {62'd0, bus_en_o, busy_o}, 64'd0);

    // R5: ack while request is still in the stages
    send_i = 1'b1; data_i = 16'h5555; dst_i = 32'h0F0F_0F0F; src_i = 16'h0042;
    tick();
    send_i = 1'b0;
    ack_i = 1'b1;
    tick();
    ack_i = 1'b0;
    chk("R5 early ack no xfer", {63'd0, bus_en_o}, 64'd0);
    tick();
    chk("R5 request still arrives", {63'd0, req_o}, 64'd1);
    ack_i = 1'b1;
    tick();
    ack_i = 1'b0;
    chk("R5 later transfer", bus_pkt_o, {32'h0F0F_0F0F, 16'h0042, 16'h5555});
    accept_i = 1'b1;
    tick();
    accept_i = 1'b0;

    // R11: reset in the middle of a request
    send_i = 1'b1;
    tick();
    send_i = 1'b0;
    tick();
    rst = 1'b1;
    tick();
    rst = 1'b0;
    chk("R11 reset drops busy", {62'd0, busy_o, req_o}, 64'd0);
    for (int k = 0; k < 4; k++) begin
      tick();
      chk("R11 no request after reset", {62'd0, req_o, bus_en_o}, 64'd0);
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule